// File: doc/BRIEF.md
# Monitor Event Trap Checker

This block evaluates a monitor-call operation against a sixteen-bit per-class enable mask taken from a control register. It receives the operation's four-bit reserved field, its four-bit class number, an already computed 24-bit effective address and the 32-bit control register. It then decides one of three outcomes: a specification exception, a monitor-event trap, or completion as a no-operation.

When a trap is raised, the block presents three values for the memory stage to write: a 16-bit interruption code with the monitor-event flag set, a 16-bit class halfword (a zero byte followed by the class byte), and a 32-bit monitor code word. Every outcome is registered one cycle after the request strobe, and a done pulse accompanies it. The block performs no memory writes of its own.

Top module: `mon_trap_chk`

## Requirements
- R1: After reset, `done_o`, `trap_o` and `spec_exc_o` are 0, and all data outputs are 0.
- R2: Exactly one cycle after a cycle with `req_i` high, `done_o` is 1 for one cycle. It is 0 in any cycle that does not follow a request.
- R3: If `rsvd_i` is non-zero, `spec_exc_o` is 1 and `trap_o` is 0 in the done cycle, whatever the mask holds.
- R4: The mask bit for class c is bit (15 - c) of `ctl_i`, counting from the LSB. Control register bits 16-31 in big-endian numbering map to classes 0-15, so class 0 is `ctl_i[15]` and class 15 is `ctl_i[0]`. Bits 31:16 of `ctl_i` have no effect.
- R5: If `rsvd_i` is zero and the selected mask bit is 1, `trap_o` is 1 and `spec_exc_o` is 0 in the done cycle.
- R6: If `rsvd_i` is zero and the selected mask bit is 0, both `trap_o` and `spec_exc_o` are 0 in the done cycle.
- R7: On a trap, `code_word_o` equals {8'h00, `addr_i`}.
- R8: On a trap, `class_hw_o` equals {8'h00, 4'h0, class}. The upper byte is the zero byte and the lower byte is the class byte.
- R9: On a trap, `int_code_o` equals 16'h0040. This is big-endian bit 9 of the 16-bit code, which is LSB-index bit 6. When there is no trap, `int_code_o`, `class_hw_o` and `code_word_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; evaluates the operands presented in this cycle |
| rsvd_i | input | 4 | Reserved operation field; must be zero |
| class_i | input | 4 | Monitor class number |
| addr_i | input | 24 | Computed effective address |
| ctl_i | input | 32 | Control register; the low 16 bits hold the class mask |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Monitor-event trap request |
| spec_exc_o | output | 1 | Specification exception |
| int_code_o | output | 16 | Interruption code |
| class_hw_o | output | 16 | Class halfword to store |
| code_word_o | output | 32 | Monitor code word to store |

## Verification
The assertions check the following on every cycle:
- trap and exception are mutually exclusive and never appear without done;
- done follows a request by exactly one cycle;
- a trap implies the reserved field of the previous cycle was zero;
- the data words are zero whenever there is no trap;
- the code word's top byte is always zero.

Only the bench scenarios can show the per-class mask mapping, the exact stored values for given operands, and that the upper control register bits have no influence. The bench covers these with random operands and directed cases at classes 0 and 15.

// File: rtl/mon_trap_chk.sv
module mon_trap_chk #(
  parameter int ADDR_W = 24,
  parameter int CLS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [3:0]        rsvd_i,
  input  logic [CLS_W-1:0]  class_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       ctl_i,
  output logic              done_o,
  output logic              trap_o,
  output logic              spec_exc_o,
  output logic [15:0]       int_code_o,
  output logic [15:0]       class_hw_o,
  output logic [31:0]       code_word_o
);
  localparam int NCLS = 1 << CLS_W;
  localparam logic [15:0] EVT_CODE = 16'h0040;

  logic [NCLS-1:0] mask;
  logic            spec, hit;

  assign mask = ctl_i[NCLS-1:0];
  assign spec = |rsvd_i;
  assign hit  = !spec && mask[NCLS-1-int'(class_i)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      trap_o      <= 1'b0;
      spec_exc_o  <= 1'b0;
      int_code_o  <= '0;
      class_hw_o  <= '0;
      code_word_o <= '0;
    end else begin
      done_o      <= req_i;
      trap_o      <= req_i && hit;
      spec_exc_o  <= req_i && spec;
      int_code_o  <= (req_i && hit) ? EVT_CODE : '0;
      class_hw_o  <= (req_i && hit) ? 16'(class_i) : '0;
      code_word_o <= (req_i && hit) ? 32'(addr_i) : '0;
    end
  end

  // R3 R5 R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_o && spec_exc_o));
  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  // R2
  no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !done_o);
  // R3
  spec_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && rsvd_i != 4'h0) |=> (spec_exc_o && !trap_o));
  // R2
  outcome_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o || spec_exc_o) |-> done_o);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> (int_code_o == 16'h0 && class_hw_o == 16'h0 && code_word_o == 32'h0));
  // R7
  code_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_word_o[31:24] == 8'h00);
endmodule

// File: tb/tb_mon_trap_chk.sv
module tb_mon_trap_chk;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, req = 0;
  logic [3:0] rsvd = 0, cls = 0;
  logic [23:0] addr = 0;
  logic [31:0] ctl = 0;
  logic done, trap, spec;
  logic [15:0] icode, chw;
  logic [31:0] cword;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  mon_trap_chk dut (.clk(clk), .rst_n(rst_n), .req_i(req), .rsvd_i(rsvd),
    .class_i(cls), .addr_i(addr), .ctl_i(ctl), .done_o(done), .trap_o(trap),
    .spec_exc_o(spec), .int_code_o(icode), .class_hw_o(chw), .code_word_o(cword));

  function automatic logic exp_trap(logic [3:0] r, logic [3:0] c, logic [31:0] k);
    return (r == 0) && k[15 - c];
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic run(logic [3:0] r, logic [3:0] c, logic [23:0] a, logic [31:0] k);
    logic t;
    t = exp_trap(r, c, k);
    @(negedge clk);
    req = 1; rsvd = r; cls = c; addr = a; ctl = k;
    @(negedge clk);
    req = 0; rsvd = $urandom; cls = $urandom; addr = $urandom; ctl = $urandom;
    chk("R2", done, 1);
    chk(r != 0 ? "R3" : (t ? "R5" : "R6"), {trap, spec}, {t, r != 0});
    chk("R4", trap, t);
    chk("R7", cword, t ? {8'h0, a} : 32'h0);
    chk("R8", chw, t ? {12'h0, c} : 16'h0);
    chk("R9", icode, t ? 16'h0040 : 16'h0);
    @(negedge clk);
    chk("R2", done, 0);
  endtask

  initial begin
    #(CLK_P*5000);
    fails++; checks++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {done, trap, spec}, 0);
    chk("R1", {icode, chw, cword}, 0);
    rst_n = 1;
    run(0, 0, 24'hABCDEF, 32'h0000_8000);  // R4 class 0 -> bit 15
    run(0, 15, 24'h123456, 32'h0000_0001); // R4 class 15 -> bit 0
    run(0, 0, 24'h111111, 32'hFFFF_7FFF);  // R4 upper bits ignored -> R6
    run(0, 15, 24'h222222, 32'hFFFF_FFFE); // R6
    run(4'h8, 3, 24'h333333, 32'hFFFF_FFFF); // R3
    run(4'h1, 7, 24'h444444, 32'h0000_FFFF); // R3
    run(0, 5, 24'hFFFFFF, 32'h0000_0400);  // R5 R8
    for (int i = 0; i < 200; i++)
      run(($urandom % 4 == 0) ? 4'($urandom) : 4'h0, 4'($urandom), 24'($urandom), $urandom);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule